// File: doc/BRIEF.md
# DMA Channel Request Handshake Controller

This block sequences one DMA channel as it works through a chain of buffer descriptors. It decides, cycle by cycle, when the next bus transfer may begin. It drives the acknowledge line toward a peripheral and decides how an external terminate signal ends the current descriptor or the whole channel. It has no address generation, descriptor storage, data path or bus arbitration. It only issues a one-cycle grant per serviced request and a one-cycle close pulse whenever the current descriptor is finished.

The channel configuration is captured from the mode inputs when a start command is accepted. These inputs are the external-request enable, the edge/level request selection, the terminate-resume choice and a 2-bit direction code. With external request disabled, the channel runs back to back and ignores the request and terminate lines. With it enabled, the channel waits for requests, which it takes either as captured rising edges or as a level sampled when the channel is waiting. It also obeys terminate, unless the direction is memory to memory. Each transfer occupies `XFER_LEN` cycles. A descriptor is closed after `BD_XFERS` transfers, or earlier by an honoured terminate.

Top module: `dma_req_ctrl`

## Requirements
- R1: With external request disabled, the channel grants a transfer in every waiting cycle with `bd_valid_i` high, so grants repeat every `XFER_LEN`+1 cycles whatever `dreq_i` does. A grant is followed by `XFER_LEN` transfer cycles, and the final one is the transfer boundary.
- R2: With external request disabled, `done_i` has no effect on grants, close pulses or `active_o`.
- R3: An active channel goes idle after a waiting cycle in which `bd_valid_i` is low or `stop_i` is high. A stop seen during a transfer is held and takes effect at that transfer's boundary.
- R4: In edge mode (`req_edge_i`=1), a rising edge of `dreq_i` seen while active is held pending, including during a busy transfer. The pending edge produces exactly one grant in the next waiting cycle.
- R5: In level mode (`req_edge_i`=0), a waiting channel grants only in cycles where `dreq_i` is high.
- R6: With external request enabled, a peripheral direction and `done_resume_i`=0, a `done_i` while active pulses `close_bd_o` in that cycle and the channel goes idle. After that, `dreq_i` produces no grant until a new start.
- R7: With `done_resume_i`=1, an honoured `done_i` pulses `close_bd_o`, aborts any transfer in progress and leaves the channel active and waiting for a new request. Pending edges are dropped.
- R8: Direction code 00 means memory to memory, 10 means peripheral to memory and 01 means memory to peripheral. With code 00, `done_i` is ignored even when external request is enabled.
- R9: `dack_o` is high exactly in the transfer cycles of a channel whose captured direction is 01 or 10.
- R10: A start with direction code 11 (reserved) leaves the channel idle and sets `cfg_err_o`. A later start with a valid code clears it.
- R11: `close_bd_o` pulses at the boundary of every `BD_XFERS`-th transfer of a descriptor. The count restarts on a start and after any close.
- R12: After reset, all outputs are low and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, accepted while idle |
| stop_i | input | 1 | Stop command |
| ext_req_i | input | 1 | External request enable (captured at start) |
| req_edge_i | input | 1 | 1: edge-sensitive requests, 0: level (captured at start) |
| done_resume_i | input | 1 | 1: terminate closes descriptor only, 0: also halts (captured at start) |
| dir_i | input | 2 | Direction code 00/01/10/11 (captured at start) |
| bd_valid_i | input | 1 | Current descriptor is valid |
| dreq_i | input | 1 | Transfer request from peripheral |
| done_i | input | 1 | External terminate |
| grant_o | output | 1 | One-cycle grant per serviced request |
| dack_o | output | 1 | Acknowledge toward the peripheral |
| close_bd_o | output | 1 | One-cycle close-descriptor pulse |
| active_o | output | 1 | Channel active |
| cfg_err_o | output | 1 | Reserved direction code seen at start |

## Verification
The bench concentrates on request edges that arrive while a transfer is still busy. A design that only looks for edges when waiting would lose those grants. It also drives terminate in the same cycle as a transfer boundary, a stop, or a pending edge. There a wrong priority shows up as a missing close pulse, a channel that stays active, or a stale edge that restarts the channel after a resume. Memory-to-memory and free-running channels are driven with terminate pulses, which a design that does not gate terminate would wrongly honour. Reserved-direction starts and stops that arrive mid-transfer check that the error flag latches correctly and that the stop waits for the transfer boundary.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_XFER = 2'd2} state_e;
  typedef enum logic [1:0] {
    DIR_M2M  = 2'b00,
    DIR_M2P  = 2'b01,
    DIR_P2M  = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;
  typedef struct packed {
    logic ext;
    logic edge_sel;
    logic resume;
    dir_e dir;
  } cfg_t;
endpackage

// File: rtl/dma_hs_req.sv
module dma_hs_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  logic en_i,
  input  logic edge_i,
  input  logic clr_i,
  input  logic take_i,
  output logic req_o
);
  logic dreq_q, pend_q, rise;

  assign rise  = dreq_i & ~dreq_q;
  assign req_o = edge_i ? pend_q : dreq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dreq_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dreq_q <= dreq_i;
      if (!en_i || !edge_i || clr_i) pend_q <= 1'b0;
      else                           pend_q <= (pend_q & ~take_i) | rise;
    end
  end

  AST_EDGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && edge_i && !clr_i && pend_q && !take_i |=> pend_q); // R4
  AST_EDGE_CAUGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && edge_i && !clr_i && dreq_i && !dreq_q |=> pend_q); // R4
endmodule

// File: rtl/dma_hs_timer.sv
module dma_hs_timer #(
  parameter int XFER_LEN = 4,
  parameter int BD_XFERS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  input  logic clr_i,
  output logic bnd_o,
  output logic last_o
);
  localparam int CW = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1;
  localparam int BW = (BD_XFERS > 1) ? $clog2(BD_XFERS) : 1;
  localparam logic [CW-1:0] CNT_TOP  = CW'(XFER_LEN - 1);
  localparam logic [BW-1:0] BEAT_TOP = BW'(BD_XFERS - 1);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] beat_q;

  assign bnd_o  = run_i && (cnt_q == '0);
  assign last_o = (beat_q == BEAT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      if (load_i)                    cnt_q <= CNT_TOP;
      else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (clr_i)      beat_q <= '0;
      else if (bnd_o) beat_q <= last_o ? '0 : beat_q + 1'b1;
    end
  end

  AST_LOAD_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_i); // R1
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_hs_pkg::*;
#(
  parameter int XFER_LEN = 4,
  parameter int BD_XFERS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ext_req_i,
  input  logic       req_edge_i,
  input  logic       done_resume_i,
  input  logic [1:0] dir_i,
  input  logic       bd_valid_i,
  input  logic       dreq_i,
  input  logic       done_i,
  output logic       grant_o,
  output logic       dack_o,
  output logic       close_bd_o,
  output logic       active_o,
  output logic       cfg_err_o
);
  state_e state_q, state_d;
  cfg_t   cfg_q;
  logic   err_q, stop_q;
  logic   honour, done_hit, stop_any, req_raw, req_ok, bnd, last;

  assign active_o = (state_q != ST_IDLE);
  assign honour   = cfg_q.ext && (cfg_q.dir != DIR_M2M);
  assign done_hit = active_o && honour && done_i;
  assign stop_any = stop_i | stop_q;
  assign req_ok   = ~cfg_q.ext | req_raw;

  dma_hs_req u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dreq_i (dreq_i),
    .en_i   (cfg_q.ext),
    .edge_i (cfg_q.edge_sel),
    .clr_i  (done_hit || state_d == ST_IDLE || state_q == ST_IDLE),
    .take_i (grant_o),
    .req_o  (req_raw)
  );

  dma_hs_timer #(.XFER_LEN(XFER_LEN), .BD_XFERS(BD_XFERS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (grant_o),
    .run_i  (state_q == ST_XFER),
    .clr_i  (done_hit || state_q == ST_IDLE),
    .bnd_o  (bnd),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    grant_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i && dir_e'(dir_i) != DIR_RSVD) state_d = ST_WAIT;
      ST_WAIT: begin
        if (done_hit)                      state_d = cfg_q.resume ? ST_WAIT : ST_IDLE;
        else if (stop_any || !bd_valid_i)  state_d = ST_IDLE;
        else if (req_ok) begin
          grant_o = 1'b1;
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (done_hit) state_d = cfg_q.resume ? ST_WAIT : ST_IDLE;
        else if (bnd) state_d = stop_any ? ST_IDLE : ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign close_bd_o = done_hit || (state_q == ST_XFER && bnd && last);
  assign dack_o     = (state_q == ST_XFER) && (cfg_q.dir != DIR_M2M);
  assign cfg_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      err_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        if (dir_e'(dir_i) == DIR_RSVD) err_q <= 1'b1;
        else begin
          err_q <= 1'b0;
          cfg_q <= '{ext: ext_req_i, edge_sel: req_edge_i, resume: done_resume_i,
                     dir: dir_e'(dir_i)};
        end
      end
      if (state_d == ST_IDLE)                     stop_q <= 1'b0;
      else if (state_q == ST_XFER && stop_i)      stop_q <= 1'b1;
    end
  end

  AST_GRANT_NEEDS_BD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> bd_valid_i && active_o && !stop_i); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !stop_i && !stop_q && bd_valid_i && !done_hit |=> active_o); // R3
  AST_DACK_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> active_o && !grant_o); // R9
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !active_o); // R10
  AST_HALT_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_hit && !cfg_q.resume |=> !active_o); // R6
  AST_RESUME_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_hit && cfg_q.resume |=> active_o && !dack_o); // R7
endmodule

// File: tb/dma_req_ctrl_test.sv
module dma_req_ctrl_test;
  localparam int CLK_P = 10;
  localparam int XL = 4;
  localparam int BX = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, ext_req_i = 0, req_edge_i = 0, done_resume_i = 0;
  logic [1:0] dir_i = 2'b00;
  logic bd_valid_i = 0, dreq_i = 0, done_i = 0;
  logic grant_o, dack_o, close_bd_o, active_o, cfg_err_o;

  int tests = 0, fails = 0;

  // reference model state: 0 idle, 1 wait, 2 transfer
  int ms = 0, m_cnt = 0, m_beat = 0;
  bit m_pend = 0, m_dq = 0, m_stopq = 0, m_err = 0;
  bit c_ext = 0, c_edge = 0, c_res = 0;
  int c_dir = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_req_ctrl #(.XFER_LEN(XL), .BD_XFERS(BX)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .ext_req_i(ext_req_i), .req_edge_i(req_edge_i), .done_resume_i(done_resume_i),
    .dir_i(dir_i), .bd_valid_i(bd_valid_i), .dreq_i(dreq_i), .done_i(done_i),
    .grant_o(grant_o), .dack_o(dack_o), .close_bd_o(close_bd_o),
    .active_o(active_o), .cfg_err_o(cfg_err_o));

  function automatic bit f_dhit();
    return (ms != 0) && c_ext && (c_dir != 0) && done_i;
  endfunction
  function automatic bit f_grant();
    bit rq = !c_ext ? 1'b1 : (c_edge ? m_pend : dreq_i);
    return ms == 1 && !f_dhit() && !(stop_i || m_stopq) && bd_valid_i && rq;
  endfunction
  function automatic bit f_close();
    return f_dhit() || (ms == 2 && m_cnt == 0 && m_beat == BX-1);
  endfunction

  task automatic cmp(input bit act, input bit exp, input string tag, input string nm);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // called just after a negedge with inputs set
  task automatic tick();
    bit eg, ec, dh, bnd;
    int nx;
    #1;
    eg = f_grant(); ec = f_close(); dh = f_dhit();
    tests++;
    cmp(grant_o, eg, !c_ext ? "R1" : (c_edge ? "R4" : "R5"), "grant_o");
    cmp(close_bd_o, ec, dh ? (c_res ? "R7" : "R6")
        : (done_i && ms != 0 && !c_ext) ? "R2"
        : (done_i && ms != 0 && c_dir == 0) ? "R8" : "R11", "close_bd_o");
    cmp(dack_o, ms == 2 && c_dir != 0, "R9", "dack_o");
    cmp(active_o, ms != 0, "R3", "active_o");
    cmp(cfg_err_o, m_err, "R10", "cfg_err_o");
    // next state
    bnd = (ms == 2) && (m_cnt == 0);
    nx = ms;
    case (ms)
      0: if (start_i && dir_i != 2'b11) nx = 1;
      1: if (dh) nx = c_res ? 1 : 0;
         else if (stop_i || m_stopq || !bd_valid_i) nx = 0;
         else if (eg) nx = 2;
      default: if (dh) nx = c_res ? 1 : 0;
               else if (bnd) nx = (stop_i || m_stopq) ? 0 : 1;
    endcase
    @(posedge clk);
    if (!(c_ext && c_edge) || ms == 0 || dh || nx == 0) m_pend = 0;
    else m_pend = (m_pend && !eg) || (dreq_i && !m_dq);
    m_dq = dreq_i;
    if (eg) m_cnt = XL-1; else if (ms == 2 && m_cnt != 0) m_cnt--;
    if (dh || ms == 0) m_beat = 0;
    else if (bnd) m_beat = (m_beat == BX-1) ? 0 : m_beat + 1;
    if (nx == 0) m_stopq = 0; else if (ms == 2 && stop_i) m_stopq = 1;
    if (ms == 0 && start_i) begin
      if (dir_i == 2'b11) m_err = 1;
      else begin
        m_err = 0; c_ext = ext_req_i; c_edge = req_edge_i;
        c_res = done_resume_i; c_dir = int'(dir_i);
      end
    end
    ms = nx;
    @(negedge clk);
    start_i = 0; stop_i = 0; done_i = 0;
  endtask

  task automatic go(input bit e, input bit ed, input bit r, input logic [1:0] d);
    ext_req_i = e; req_edge_i = ed; done_resume_i = r; dir_i = d; start_i = 1;
    tick();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_P*3);
    @(negedge clk);
    tests++; // R12 reset state
    if ({grant_o, dack_o, close_bd_o, active_o, cfg_err_o} !== 5'b0) begin
      fails++;
      $display("FAIL R12 outputs actual=%05b expected=00000",
               {grant_o, dack_o, close_bd_o, active_o, cfg_err_o});
    end
    rst_ni = 1;
    @(negedge clk);
    bd_valid_i = 1;

    // R1/R11 free run, R9 dack, dreq ignored
    go(0, 0, 0, 2'b01); dreq_i = 0; idle_n(20);
    // R2 done ignored in free run
    done_i = 1; tick(); done_i = 1; idle_n(3); stop_i = 1; idle_n(8);
    // R10 reserved code, then cleared
    go(1, 1, 0, 2'b11); idle_n(3); go(1, 1, 0, 2'b10); idle_n(2);
    // R4 edge during busy transfer
    dreq_i = 1; tick(); dreq_i = 0; idle_n(2); dreq_i = 1; tick(); dreq_i = 0; idle_n(12);
    // R6 done halts, later dreq ignored
    dreq_i = 1; tick(); dreq_i = 0; tick(); done_i = 1; tick(); dreq_i = 1; idle_n(5); dreq_i = 0;
    // R7 resume, R5 level mode
    go(1, 0, 1, 2'b01); dreq_i = 1; idle_n(3); done_i = 1; tick(); dreq_i = 0; idle_n(4);
    dreq_i = 1; idle_n(6); stop_i = 1; tick(); idle_n(6);
    // R8 m2m with external request ignores done
    go(1, 0, 0, 2'b00); dreq_i = 1; idle_n(2); done_i = 1; tick(); idle_n(4);
    // R3 descriptor runs out
    bd_valid_i = 0; idle_n(8); bd_valid_i = 1; dreq_i = 0;

    for (int s = 0; s < 30; s++) begin
      logic [1:0] d = 2'($urandom_range(0, 3));
      go(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), d);
      for (int c = 0; c < 150; c++) begin
        dreq_i     = ($urandom_range(0, 9) < 3);
        done_i     = ($urandom_range(0, 39) == 0);
        stop_i     = ($urandom_range(0, 59) == 0);
        start_i    = ($urandom_range(0, 19) == 0);
        bd_valid_i = ($urandom_range(0, 19) != 0);
        ext_req_i  = 1'($urandom_range(0, 1));
        req_edge_i = 1'($urandom_range(0, 1));
        done_resume_i = 1'($urandom_range(0, 1));
        dir_i      = 2'($urandom_range(0, 3));
        tick();
      end
      stop_i = 1; tick(); idle_n(XL+2);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule